// File: doc/BRIEF.md
# Serial Command Port for an I/O Controller

This block is a slave-side serial port through which an external I/O controller sets up the system and reads back the state of the disk DMA. The controller frames each transaction with an active-low select. The first byte is a command. The bytes after it carry that command's payload, most significant bit first. The port is clocked by the system clock. It oversamples the serial clock, select and data through a short synchronizer chain, so the serial clock must run several times slower than the system clock.

Configuration commands load a 32-bit control word and a 16-bit video adjustment word. A third command loads the DMA set-up: a sector count, a word address and a transfer direction packed into the top address bit. A status command returns a fixed 16-byte snapshot of the DMA and disk-controller state. The two memory data commands are only decoded here. Each incoming payload byte is handed to the transfer engine with a one-cycle strobe. For the read command, each reply byte is pulled from the engine with a one-cycle request.

Top module: `spi_cmd_port`

## Requirements
- R1: After reset, `ctrl_word` and `vid_adjust` are zero, `spi_miso` is low, and no strobe output is high.
- R2: `spi_mosi` is sampled on each rising `spi_sck` edge, MSB first, eight edges per byte. A reply bit appears on `spi_miso` shortly after a rising edge and stays put until the next rising edge, so the master can read it before that edge. The first bit of a reply byte is present before that byte's first rising edge.
- R3: Command 0x04 takes four payload bytes, most significant first. `ctrl_word` takes the whole 32-bit value one cycle after the fourth byte completes, and not before.
- R4: Command 0x09 takes two payload bytes. `vid_adjust` becomes {first, second} after the second byte.
- R5: Command 0x01 takes a sector-count byte and then three bytes of a 24-bit word address, high byte first. After the last byte, `dma_load` pulses for one cycle. With it, `dma_sectors` carries the count, `dma_word_addr` carries the low 23 address bits, and `dma_to_host` carries address bit 23 (1 = memory read toward the controller).
- R6: When the sector count of command 0x01 is zero, `dma_stop` pulses in the same cycle as `dma_load`. Otherwise `dma_stop` stays low.
- R7: Command 0x05 replies with 16 bytes, one per following byte slot:
  - bytes 0 to 2: `st_word_addr` shifted left by one (a byte address), high byte first, with bit 0 of byte 2 reading 0;
  - byte 3: `st_sectors`;
  - bytes 4, 5, 6, 7: `fd_cmd`, `fd_track`, `fd_sector`, `fd_data`;
  - byte 8: `fd_busy` in bit 0;
  - byte 10: `fifo_rd_ptr` in the high nibble and `fifo_wr_ptr` in the low nibble;
  - byte 15: `hd_busy` in bit 0.

  Bytes 9 and 11 to 14, and every byte after the sixteenth, read 0x00.
- R8: After command 0x02, every complete payload byte appears on `mem_wr_data` with a one-cycle `mem_wr_valid`.
- R9: After command 0x03, `mem_rd_req` pulses once when the command byte completes and once when each payload byte completes. `mem_rd_data` is taken in that same cycle and becomes the next reply byte.
- R10: Command 0x06 pulses `cmd_ack` once and command 0x0A pulses `cmd_reject` once. Bytes after either command are ignored.
- R11: Raising `spi_ss_n` discards a partial byte and the current command. A payload cut short changes no output, and the next transaction starts afresh with a command byte.
- R12: Bytes after an unknown command code change no output and raise no strobe.
- R13: `spi_miso` is low while deselected, during the command byte, and for commands that have no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_ss_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| ctrl_word | output | 32 | Control word |
| vid_adjust | output | 16 | Video adjustment word |
| dma_load | output | 1 | One-cycle DMA set-up strobe |
| dma_stop | output | 1 | One-cycle stop strobe (zero sector count) |
| dma_sectors | output | 8 | Sector count, valid with `dma_load` |
| dma_word_addr | output | 23 | Word address, valid with `dma_load` |
| dma_to_host | output | 1 | Direction, 1 = memory read toward controller |
| mem_wr_valid | output | 1 | Memory-write byte strobe |
| mem_wr_data | output | 8 | Memory-write byte |
| mem_rd_req | output | 1 | Memory-read byte request |
| mem_rd_data | input | 8 | Memory-read byte, taken with `mem_rd_req` |
| cmd_ack | output | 1 | Acknowledge strobe |
| cmd_reject | output | 1 | Reject strobe |
| st_word_addr | input | 23 | Current DMA word address |
| st_sectors | input | 8 | Current sector count |
| fd_cmd | input | 8 | Floppy command register |
| fd_track | input | 8 | Floppy track register |
| fd_sector | input | 8 | Floppy sector register |
| fd_data | input | 8 | Floppy data register |
| fd_busy | input | 1 | Floppy busy flag |
| fifo_rd_ptr | input | 4 | Transfer FIFO read pointer |
| fifo_wr_ptr | input | 4 | Transfer FIFO write pointer |
| hd_busy | input | 1 | Hard-disk busy flag |

## Verification
The bench goes after the byte-boundary hand-offs. If the reply byte were loaded one edge late, the status snapshot would come back shifted by one bit or one byte. If the read request were not raised at the command byte itself, the first read byte would be lost. A port that committed each control byte as it arrived would show a half-written control word after a transaction cut short. A port that forgot to clear its bit counter on deselect would misframe every byte of the next transaction. The zero-count stop pulse, the direction taken from the top address bit, the zero bytes past the end of the snapshot, and the silence after unknown, acknowledge and reject codes are each checked at the ports.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [7:0] OP_SET_ADDR  = 8'h01;
  localparam logic [7:0] OP_MEM_WR    = 8'h02;
  localparam logic [7:0] OP_MEM_RD    = 8'h03;
  localparam logic [7:0] OP_SET_CTRL  = 8'h04;
  localparam logic [7:0] OP_GET_STATE = 8'h05;
  localparam logic [7:0] OP_ACK       = 8'h06;
  localparam logic [7:0] OP_SET_VADJ  = 8'h09;
  localparam logic [7:0] OP_REJECT    = 8'h0A;

  localparam int SNAP_BYTES = 16;
  localparam int WADDR_W    = 23;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_MWR, PH_MRD, PH_CTRL, PH_STAT, PH_VADJ, PH_SKIP
  } phase_e;

  typedef struct packed {
    logic [WADDR_W-1:0] waddr;
    logic [7:0]         sectors;
    logic [7:0]         fd_cmd;
    logic [7:0]         fd_track;
    logic [7:0]         fd_sector;
    logic [7:0]         fd_data;
    logic               fd_busy;
    logic [3:0]         fifo_rd;
    logic [3:0]         fifo_wr;
    logic               hd_busy;
  } snap_t;

  // Phase entered once a command byte has been received.
  function automatic phase_e op_phase(input logic [7:0] op);
    case (op)
      OP_SET_ADDR:  return PH_ADDR;
      OP_MEM_WR:    return PH_MWR;
      OP_MEM_RD:    return PH_MRD;
      OP_SET_CTRL:  return PH_CTRL;
      OP_GET_STATE: return PH_STAT;
      OP_SET_VADJ:  return PH_VADJ;
      default:      return PH_SKIP;
    endcase
  endfunction

  // Byte k of the status reply; the word address is shown as a byte address.
  function automatic logic [7:0] snap_byte(input snap_t s, input logic [3:0] k);
    case (k)
      4'd0:    return s.waddr[22:15];
      4'd1:    return s.waddr[14:7];
      4'd2:    return {s.waddr[6:0], 1'b0};
      4'd3:    return s.sectors;
      4'd4:    return s.fd_cmd;
      4'd5:    return s.fd_track;
      4'd6:    return s.fd_sector;
      4'd7:    return s.fd_data;
      4'd8:    return {7'd0, s.fd_busy};
      4'd10:   return {s.fifo_rd, s.fifo_wr};
      4'd15:   return {7'd0, s.hd_busy};
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ss_n_i,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_next,
  output logic       active,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sck_q, ss_q, mosi_q;
  logic       sck_d;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;
  logic       sck_rise;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_q[0]  <= 1'b0;
          ss_q[0]   <= 1'b1;
          mosi_q[0] <= 1'b0;
        end else begin
          sck_q[0]  <= sck_i;
          ss_q[0]   <= ss_n_i;
          mosi_q[0] <= mosi_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_q[g]  <= 1'b0;
          ss_q[g]   <= 1'b1;
          mosi_q[g] <= 1'b0;
        end else begin
          sck_q[g]  <= sck_q[g-1];
          ss_q[g]   <= ss_q[g-1];
          mosi_q[g] <= mosi_q[g-1];
        end
      end
    end
  end

  assign active    = ~ss_q[LAST];
  assign sck_rise  = active & sck_q[LAST] & ~sck_d;
  assign byte_done = sck_rise & (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sr, mosi_q[LAST]};
  assign miso      = tx_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      bit_cnt <= 3'd0;
      rx_sr   <= 7'd0;
      tx_sr   <= 8'd0;
    end else begin
      sck_d <= sck_q[LAST];
      if (!active) begin
        bit_cnt <= 3'd0;
        rx_sr   <= 7'd0;
        tx_sr   <= 8'd0;
      end else if (sck_rise) begin
        rx_sr   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) tx_sr <= tx_next;
        else                 tx_sr <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  assert_quiet_deselect_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (miso == 1'b0));

  assert_bits_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (bit_cnt == 3'd0 && rx_sr == 7'd0));

  assert_stable_between_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sck_rise && $past(active)) |=> $stable(miso));

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int CTRL_BYTES = 4,
  parameter int VADJ_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   active,
  input  logic                   byte_done,
  input  logic [7:0]             rx_byte,
  input  snap_t                  snap,
  input  logic [7:0]             mem_rd_data,
  output logic [7:0]             tx_next,
  output logic [8*CTRL_BYTES-1:0] ctrl_word,
  output logic [8*VADJ_BYTES-1:0] vid_adjust,
  output logic                   dma_load,
  output logic                   dma_stop,
  output logic [7:0]             dma_sectors,
  output logic [WADDR_W-1:0]     dma_word_addr,
  output logic                   dma_to_host,
  output logic                   mem_wr_valid,
  output logic [7:0]             mem_wr_data,
  output logic                   mem_rd_req,
  output logic                   cmd_ack,
  output logic                   cmd_reject
);
  localparam int CTRL_W = 8 * CTRL_BYTES;
  localparam int VADJ_W = 8 * VADJ_BYTES;
  localparam int IDX_W  = $clog2(SNAP_BYTES + 1);
  localparam logic [IDX_W-1:0] CTRL_LAST = IDX_W'(CTRL_BYTES - 1);
  localparam logic [IDX_W-1:0] VADJ_LAST = IDX_W'(VADJ_BYTES - 1);
  localparam logic [IDX_W-1:0] SNAP_END  = IDX_W'(SNAP_BYTES);

  phase_e           phase;
  logic [IDX_W-1:0] idx;
  logic [CTRL_W-9:0] ctrl_shadow;
  logic [VADJ_W-9:0] vadj_shadow;
  logic [7:0]        sect_shadow;
  logic [15:0]       addr_shadow;
  logic [CTRL_W-1:0] ctrl_next;
  logic [VADJ_W-1:0] vadj_next;
  logic [23:0]       addr_next;
  logic              ctrl_upd, vadj_upd;
  logic              cmd_is_rd, cmd_is_stat;

  assign ctrl_next   = {ctrl_shadow, rx_byte};
  assign vadj_next   = {vadj_shadow, rx_byte};
  assign addr_next   = {addr_shadow, rx_byte};
  assign cmd_is_rd   = (phase == PH_CMD) && (rx_byte == OP_MEM_RD);
  assign cmd_is_stat = (phase == PH_CMD) && (rx_byte == OP_GET_STATE);
  assign mem_rd_req  = byte_done && (cmd_is_rd || phase == PH_MRD);

  always_comb begin
    tx_next = 8'h00;
    if (cmd_is_rd || phase == PH_MRD) tx_next = mem_rd_data;
    else if (cmd_is_stat)             tx_next = snap_byte(snap, 4'd0);
    else if (phase == PH_STAT && idx < SNAP_END)
      tx_next = snap_byte(snap, idx[3:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= PH_CMD;
      idx           <= '0;
      ctrl_shadow   <= '0;
      vadj_shadow   <= '0;
      sect_shadow   <= '0;
      addr_shadow   <= '0;
      ctrl_word     <= '0;
      vid_adjust    <= '0;
      dma_load      <= 1'b0;
      dma_stop      <= 1'b0;
      dma_sectors   <= '0;
      dma_word_addr <= '0;
      dma_to_host   <= 1'b0;
      mem_wr_valid  <= 1'b0;
      mem_wr_data   <= '0;
      cmd_ack       <= 1'b0;
      cmd_reject    <= 1'b0;
      ctrl_upd      <= 1'b0;
      vadj_upd      <= 1'b0;
    end else begin
      dma_load     <= 1'b0;
      dma_stop     <= 1'b0;
      mem_wr_valid <= 1'b0;
      cmd_ack      <= 1'b0;
      cmd_reject   <= 1'b0;
      ctrl_upd     <= 1'b0;
      vadj_upd     <= 1'b0;
      if (!active) begin
        phase <= PH_CMD;
        idx   <= '0;
      end else if (byte_done) begin
        case (phase)
          PH_CMD: begin
            phase      <= op_phase(rx_byte);
            idx        <= cmd_is_stat ? IDX_W'(1) : '0;
            cmd_ack    <= (rx_byte == OP_ACK);
            cmd_reject <= (rx_byte == OP_REJECT);
          end
          PH_ADDR: begin
            idx <= idx + 1'b1;
            if (idx == '0) sect_shadow <= rx_byte;
            else           addr_shadow <= addr_next[15:0];
            if (idx == IDX_W'(3)) begin
              dma_load      <= 1'b1;
              dma_stop      <= (sect_shadow == 8'd0);
              dma_sectors   <= sect_shadow;
              dma_to_host   <= addr_next[23];
              dma_word_addr <= addr_next[22:0];
              phase         <= PH_SKIP;
            end
          end
          PH_CTRL: begin
            idx         <= idx + 1'b1;
            ctrl_shadow <= ctrl_next[CTRL_W-9:0];
            if (idx == CTRL_LAST) begin
              ctrl_word <= ctrl_next;
              ctrl_upd  <= 1'b1;
              phase     <= PH_SKIP;
            end
          end
          PH_VADJ: begin
            idx         <= idx + 1'b1;
            vadj_shadow <= vadj_next[VADJ_W-9:0];
            if (idx == VADJ_LAST) begin
              vid_adjust <= vadj_next;
              vadj_upd   <= 1'b1;
              phase      <= PH_SKIP;
            end
          end
          PH_MWR: begin
            mem_wr_valid <= 1'b1;
            mem_wr_data  <= rx_byte;
          end
          PH_STAT: begin
            if (idx < SNAP_END) idx <= idx + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assert_stop_needs_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stop |-> (dma_load && dma_sectors == 8'd0));

  assert_one_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_load, ctrl_upd, vadj_upd, mem_wr_valid, cmd_ack, cmd_reject}));

  assert_ctrl_only_on_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(ctrl_word));

  assert_vadj_only_on_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(vid_adjust));

  assert_rdreq_enters_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> (phase == PH_MRD));

  assert_skip_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |=> (phase == PH_SKIP || phase == PH_CMD));

  assert_deselect_resets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (phase == PH_CMD));

endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_ss_n,
  input  logic        spi_sck,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic [31:0] ctrl_word,
  output logic [15:0] vid_adjust,
  output logic        dma_load,
  output logic        dma_stop,
  output logic [7:0]  dma_sectors,
  output logic [22:0] dma_word_addr,
  output logic        dma_to_host,
  output logic        mem_wr_valid,
  output logic [7:0]  mem_wr_data,
  output logic        mem_rd_req,
  input  logic [7:0]  mem_rd_data,
  output logic        cmd_ack,
  output logic        cmd_reject,
  input  logic [22:0] st_word_addr,
  input  logic [7:0]  st_sectors,
  input  logic [7:0]  fd_cmd,
  input  logic [7:0]  fd_track,
  input  logic [7:0]  fd_sector,
  input  logic [7:0]  fd_data,
  input  logic        fd_busy,
  input  logic [3:0]  fifo_rd_ptr,
  input  logic [3:0]  fifo_wr_ptr,
  input  logic        hd_busy
);
  logic       active, byte_done;
  logic [7:0] rx_byte, tx_next;
  snap_t      snap;

  assign snap = '{waddr: st_word_addr, sectors: st_sectors, fd_cmd: fd_cmd,
                  fd_track: fd_track, fd_sector: fd_sector, fd_data: fd_data,
                  fd_busy: fd_busy, fifo_rd: fifo_rd_ptr, fifo_wr: fifo_wr_ptr,
                  hd_busy: hd_busy};

  spi_bit_engine #(.SYNC_STAGES(SYNC_STAGES)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .ss_n_i   (spi_ss_n),
    .sck_i    (spi_sck),
    .mosi_i   (spi_mosi),
    .tx_next  (tx_next),
    .active   (active),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .miso     (spi_miso)
  );

  spi_cmd_decoder #(.CTRL_BYTES(4), .VADJ_BYTES(2)) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (active),
    .byte_done    (byte_done),
    .rx_byte      (rx_byte),
    .snap         (snap),
    .mem_rd_data  (mem_rd_data),
    .tx_next      (tx_next),
    .ctrl_word    (ctrl_word),
    .vid_adjust   (vid_adjust),
    .dma_load     (dma_load),
    .dma_stop     (dma_stop),
    .dma_sectors  (dma_sectors),
    .dma_word_addr(dma_word_addr),
    .dma_to_host  (dma_to_host),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_data  (mem_wr_data),
    .mem_rd_req   (mem_rd_req),
    .cmd_ack      (cmd_ack),
    .cmd_reject   (cmd_reject)
  );

  assert_load_after_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_load |-> $past(byte_done));

endmodule

// File: tb/test_spi_cmd_port.sv
module test_spi_cmd_port;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  logic [31:0] ctrl_word;
  logic [15:0] vid_adjust;
  logic dma_load, dma_stop, dma_to_host;
  logic [7:0] dma_sectors;
  logic [22:0] dma_word_addr;
  logic mem_wr_valid, mem_rd_req, cmd_ack, cmd_reject;
  logic [7:0] mem_wr_data, mem_rd_data;
  logic [22:0] st_word_addr = 23'h7E1234;
  logic [7:0] st_sectors = 8'h05, fd_cmd = 8'h13, fd_track = 8'h27;
  logic [7:0] fd_sector = 8'h09, fd_data = 8'hC4;
  logic fd_busy = 1'b1, hd_busy = 1'b1;
  logic [3:0] fifo_rd_ptr = 4'h6, fifo_wr_ptr = 4'hB;

  always #5 clk = ~clk;

  spi_cmd_port i_spi_cmd_port (
    .clk(clk), .rst_n(rst_n), .spi_ss_n(ss_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .ctrl_word(ctrl_word), .vid_adjust(vid_adjust),
    .dma_load(dma_load), .dma_stop(dma_stop), .dma_sectors(dma_sectors),
    .dma_word_addr(dma_word_addr), .dma_to_host(dma_to_host),
    .mem_wr_valid(mem_wr_valid), .mem_wr_data(mem_wr_data),
    .mem_rd_req(mem_rd_req), .mem_rd_data(mem_rd_data),
    .cmd_ack(cmd_ack), .cmd_reject(cmd_reject),
    .st_word_addr(st_word_addr), .st_sectors(st_sectors), .fd_cmd(fd_cmd),
    .fd_track(fd_track), .fd_sector(fd_sector), .fd_data(fd_data),
    .fd_busy(fd_busy), .fifo_rd_ptr(fifo_rd_ptr), .fifo_wr_ptr(fifo_wr_ptr),
    .hd_busy(hd_busy)
  );

  // Bench-side bookkeeping of strobes
  int load_cnt = 0, stop_cnt = 0, wr_cnt = 0, rd_cnt = 0, ack_cnt = 0, nak_cnt = 0;
  int strobe_cnt = 0;
  logic [7:0] wr_log [16];
  logic [7:0] cap_sect;
  logic [22:0] cap_addr;
  logic cap_dir;

  assign mem_rd_data = 8'hA0 + rd_cnt[7:0];

  always @(posedge clk) begin
    if (dma_load) begin
      load_cnt <= load_cnt + 1;
      cap_sect <= dma_sectors; cap_addr <= dma_word_addr; cap_dir <= dma_to_host;
    end
    if (dma_stop) stop_cnt <= stop_cnt + 1;
    if (mem_wr_valid) begin
      wr_log[wr_cnt[3:0]] <= mem_wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_rd_req) rd_cnt <= rd_cnt + 1;
    if (cmd_ack) ack_cnt <= ack_cnt + 1;
    if (cmd_reject) nak_cnt <= nak_cnt + 1;
    if (dma_load | dma_stop | mem_wr_valid | mem_rd_req | cmd_ack | cmd_reject)
      strobe_cnt <= strobe_cnt + 1;
  end

  int n_vec = 0, n_err = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sel();
    @(negedge clk); ss_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    repeat (4) @(negedge clk);
    ss_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  // cmd in [39:32], payload bytes in [31:24],[23:16],[15:8],[7:0]
  localparam logic [39:0] VEC [8] = '{
    {8'h04, 32'h12345678}, {8'h09, 32'hBEEF0000}, {8'h01, 32'h047E0000},
    {8'h04, 32'hA5C30FF0}, {8'h01, 32'h02FE0000}, {8'h09, 32'h12340000},
    {8'h01, 32'h00000000}, {8'h01, 32'hFF800001}
  };

  function automatic int payload_len(input logic [7:0] op);
    return (op == 8'h09) ? 2 : 4;
  endfunction

  function automatic logic [7:0] status_exp(input int k);
    logic [23:0] ba;
    ba = {st_word_addr, 1'b0};
    case (k)
      0: return ba[23:16];
      1: return ba[15:8];
      2: return ba[7:0];
      3: return st_sectors;
      4: return fd_cmd;
      5: return fd_track;
      6: return fd_sector;
      7: return fd_data;
      8: return {7'd0, fd_busy};
      10: return {fifo_rd_ptr, fifo_wr_ptr};
      15: return {7'd0, hd_busy};
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [31:0] ctrl_m;
    logic [15:0] vadj_m;
    int base, lc, sc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 ctrl", ctrl_word, 0);
    check("R1 vadj", {16'd0, vid_adjust}, 0);
    check("R1 miso", {31'd0, miso}, 0);
    check("R1 strobes", strobe_cnt, 0);

    // Table walk: R3 R4 R5 R6
    ctrl_m = 0; vadj_m = 0;
    for (int v = 0; v < 8; v++) begin
      logic [7:0] op;
      logic [31:0] p;
      op = VEC[v][39:32]; p = VEC[v][31:0];
      lc = load_cnt; sc = stop_cnt;
      sel();
      xfer(op, r);
      for (int i = 0; i < payload_len(op); i++) xfer(p[31-8*i -: 8], r);
      desel();
      if (op == 8'h04) ctrl_m = p;
      if (op == 8'h09) vadj_m = p[31:16];
      check("R3 ctrl", ctrl_word, ctrl_m);
      check("R4 vadj", {16'd0, vid_adjust}, {16'd0, vadj_m});
      if (op == 8'h01) begin
        check("R5 load count", load_cnt, lc + 1);
        check("R5 sectors", {24'd0, cap_sect}, {24'd0, p[31:24]});
        check("R5 word addr", {9'd0, cap_addr}, {9'd0, p[22:0]});
        check("R5 direction", {31'd0, cap_dir}, {31'd0, p[23]});
        check("R6 stop", stop_cnt, sc + ((p[31:24] == 0) ? 1 : 0));
      end else begin
        check("R5 no load", load_cnt, lc);
      end
    end

    // R7 R2 R13 status snapshot, two bytes past the end
    sel();
    xfer(8'h05, r);
    check("R13 miso during command", {24'd0, r}, 0);
    for (int k = 0; k < 18; k++) begin
      xfer(8'h00, r);
      check((k == 0) ? "R2 first reply byte" : "R7 status byte", {24'd0, r},
            {24'd0, status_exp(k)});
    end
    desel();

    // R8 memory write stream
    base = wr_cnt;
    sel();
    xfer(8'h02, r);
    for (int i = 0; i < 5; i++) xfer(8'h31 + 8'(i * 17), r);
    desel();
    check("R8 byte count", wr_cnt, base + 5);
    for (int i = 0; i < 5; i++)
      check("R8 byte value", {24'd0, wr_log[(base + i) % 16]}, {24'd0, 8'h31 + 8'(i * 17)});

    // R9 memory read stream
    base = rd_cnt;
    sel();
    xfer(8'h03, r);
    for (int i = 0; i < 4; i++) begin
      xfer(8'h00, r);
      check("R9 read byte", {24'd0, r}, {24'd0, 8'hA0 + 8'(base + i)});
    end
    desel();
    check("R9 request count", rd_cnt, base + 5);

    // R10 acknowledge and reject; following bytes ignored
    sel(); xfer(8'h06, r); xfer(8'h04, r); xfer(8'h55, r); desel();
    check("R10 ack", ack_cnt, 1);
    sel(); xfer(8'h0A, r); xfer(8'h09, r); xfer(8'h66, r); xfer(8'h77, r); desel();
    check("R10 reject", nak_cnt, 1);
    check("R10 ctrl kept", ctrl_word, ctrl_m);
    check("R10 vadj kept", {16'd0, vid_adjust}, {16'd0, vadj_m});
    check("R13 no reply on ack", {31'd0, miso}, 0);

    // R11 cut-short payload commits nothing
    sel(); xfer(8'h04, r); xfer(8'hDE, r); xfer(8'hAD, r); desel();
    check("R11 partial ctrl", ctrl_word, ctrl_m);
    // R11 partial byte discarded: five bits then deselect
    sel();
    for (int b = 7; b >= 3; b--) begin
      mosi = b[0];
      repeat (HALF) @(negedge clk); sck = 1'b1;
      repeat (HALF) @(negedge clk); sck = 0;
    end
    desel();
    sel(); xfer(8'h09, r); xfer(8'h11, r); xfer(8'h22, r); desel();
    check("R11 fresh frame", {16'd0, vid_adjust}, 32'h1122);
    vadj_m = 16'h1122;

    // R12 unknown command
    sc = strobe_cnt;
    sel(); xfer(8'h07, r); xfer(8'h04, r); xfer(8'h01, r); xfer(8'h02, r); xfer(8'h03, r); desel();
    check("R12 no strobe", strobe_cnt, sc);
    check("R12 ctrl kept", ctrl_word, ctrl_m);
    check("R12 vadj kept", {16'd0, vid_adjust}, {16'd0, vadj_m});
    check("R13 miso idle", {31'd0, miso}, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule